// File: doc/BRIEF.md
# Transaction ID Remapping Table

This block sits in an I/O bridge between a target port that receives requests and an initiator port that forwards them. Each accepted request claims a free slot in a small tag table. The slot keeps the requester's source ID, transaction ID and packet ID. The request then leaves with the bridge's own fixed source ID, and its transaction ID field holds the slot index. Because of this, the response has to come back through the same bridge.

When a response arrives, its transaction ID is used as the slot index. The stored IDs are read out, and the response leaves on the return port carrying the requester's original IDs. The slot is released when that outgoing response completes its handshake. All four channels use valid/ready handshakes. The forward request path and the return path each have one register stage. The return stage works as the holding register between the two sides, so a request accepted later cannot disturb a response that is waiting to leave.

Top module: `xid_remap_table`

## Requirements
- R1: While the synchronous active-low reset is asserted, every slot becomes free and both output stages become empty. After release, `req_out_valid` and `rsp_out_valid` are 0 and `req_in_ready` is 1.
- R2: A request accepted on the incoming channel appears on the outgoing request channel in the following cycle. Its source ID is the parameter `OWN_SRC`, its packet ID is unchanged, and its transaction ID is the allocated slot index, zero-extended.
- R3: The allocated slot is always the lowest-numbered free slot at the time of the handshake.
- R4: `req_in_ready` is 1 exactly when at least one slot is free and the outgoing request stage is empty or being drained (`!req_out_valid || req_out_ready`). With every slot in use it stays 0.
- R5: A response whose transaction ID names an allocated slot appears on the return channel in the following cycle. It carries the stored source, transaction and packet IDs, with `rsp_out_err` equal to 0.
- R6: A slot is released in the cycle its response completes the `rsp_out_valid && rsp_out_ready` handshake. A release and an allocation in the same cycle both take effect. A released slot can be allocated again from the next cycle onwards.
- R7: A response is marked as an error in three cases: its transaction ID is at least `DEPTH`, it names a free slot, or it names the slot whose response is already waiting in the return stage. Such a response is forwarded with `rsp_out_err` equal to 1 and all ID fields 0, and it changes no slot.
- R8: Both output stages hold their contents while valid and not ready. `rsp_in_ready` equals `!rsp_out_valid || rsp_out_ready`.
- R9: While a response waits in the return stage, accepting new requests does not change any of its fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_in_valid | input | 1 | Incoming request valid |
| req_in_ready | output | 1 | Incoming request accepted |
| req_in_src | input | SRC_W | Requester source ID |
| req_in_tid | input | TID_W | Requester transaction ID |
| req_in_pkt | input | PKT_W | Requester packet ID |
| req_out_valid | output | 1 | Forwarded request valid |
| req_out_ready | input | 1 | Forwarded request accepted |
| req_out_src | output | SRC_W | Bridge's fixed source ID |
| req_out_tid | output | TID_W | Allocated slot index |
| req_out_pkt | output | PKT_W | Packet ID, unchanged |
| rsp_in_valid | input | 1 | Returning response valid |
| rsp_in_ready | output | 1 | Returning response accepted |
| rsp_in_tid | input | TID_W | Slot index carried by the response |
| rsp_out_valid | output | 1 | Restored response valid |
| rsp_out_ready | input | 1 | Restored response accepted |
| rsp_out_src | output | SRC_W | Restored source ID |
| rsp_out_tid | output | TID_W | Restored transaction ID |
| rsp_out_pkt | output | PKT_W | Restored packet ID |
| rsp_out_err | output | 1 | Response named no valid slot |

## Verification
Every result of this block is due exactly one rising edge after its cause:
- A forwarded request appears one edge after the input handshake.
- A restored or error response appears one edge after it is captured.
- A slot is taken or freed at the edge of the handshake that caused it, so a freed slot shows in `req_in_ready` one edge after the outgoing response handshake.

The ready outputs are combinational in the present inputs and the current slot state. The bench drives inputs on the falling edge. A reference model is advanced on each rising edge, and the bench compares on the next falling edge, so each check looks at the cycle in which the requirement says the value is due.

// File: rtl/xid_remap_pkg.sv
package xid_remap_pkg;

  // Width of a slot index for a table of the given depth (at least one bit).
  function automatic int idx_width(input int depth);
    return (depth > 1) ? $clog2(depth) : 1;
  endfunction

  // Mask of all slot positions strictly below idx (depth up to 64).
  function automatic logic [63:0] below_mask(input int idx);
    return (64'd1 << idx) - 64'd1;
  endfunction

  // True when a returned transaction ID addresses an existing slot.
  function automatic logic in_table(input logic [63:0] tid, input int depth);
    return tid < 64'(depth);
  endfunction

endpackage

// File: rtl/xid_pick_free.sv
module xid_pick_free #(
  parameter int DEPTH = 4,
  parameter int IDX_W = 2
) (
  input  logic [DEPTH-1:0] busy,
  output logic             any_free,
  output logic [IDX_W-1:0] free_idx
);
  // Lowest-numbered clear bit wins: scan downward so the last hit is the lowest.
  always_comb begin
    free_idx = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (!busy[i]) free_idx = IDX_W'(i);
    end
  end

  assign any_free = ~&busy;
endmodule

// File: rtl/xid_tag_table.sv
module xid_tag_table #(
  parameter int DEPTH = 4,
  parameter int IDX_W = 2,
  parameter int SRC_W = 8,
  parameter int TID_W = 4,
  parameter int PKT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [SRC_W-1:0] wr_src,
  input  logic [TID_W-1:0] wr_tid,
  input  logic [PKT_W-1:0] wr_pkt,
  input  logic             clr_en,
  input  logic [IDX_W-1:0] clr_idx,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [SRC_W-1:0] rd_src,
  output logic [TID_W-1:0] rd_tid,
  output logic [PKT_W-1:0] rd_pkt,
  output logic [DEPTH-1:0] busy
);
  logic [SRC_W-1:0] src_q [DEPTH];
  logic [TID_W-1:0] tid_q [DEPTH];
  logic [PKT_W-1:0] pkt_q [DEPTH];

  for (genvar e = 0; e < DEPTH; e++) begin : g_slot
    logic hit_wr, hit_clr;
    assign hit_wr  = wr_en  && (wr_idx  == IDX_W'(e));
    assign hit_clr = clr_en && (clr_idx == IDX_W'(e));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        busy[e]  <= 1'b0;
        src_q[e] <= '0;
        tid_q[e] <= '0;
        pkt_q[e] <= '0;
      end else begin
        // A slot is never written and cleared in one cycle: writes go to free slots only.
        if (hit_wr) begin
          busy[e]  <= 1'b1;
          src_q[e] <= wr_src;
          tid_q[e] <= wr_tid;
          pkt_q[e] <= wr_pkt;
        end else if (hit_clr) begin
          busy[e]  <= 1'b0;
        end
      end
    end
  end

  assign rd_src = src_q[rd_idx];
  assign rd_tid = tid_q[rd_idx];
  assign rd_pkt = pkt_q[rd_idx];
endmodule

// File: rtl/xid_remap_table.sv
module xid_remap_table
  import xid_remap_pkg::*;
#(
  parameter int               DEPTH   = 4,
  parameter int               SRC_W   = 8,
  parameter int               TID_W   = 4,
  parameter int               PKT_W   = 4,
  parameter logic [SRC_W-1:0] OWN_SRC = 8'hA5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_in_valid,
  output logic             req_in_ready,
  input  logic [SRC_W-1:0] req_in_src,
  input  logic [TID_W-1:0] req_in_tid,
  input  logic [PKT_W-1:0] req_in_pkt,
  output logic             req_out_valid,
  input  logic             req_out_ready,
  output logic [SRC_W-1:0] req_out_src,
  output logic [TID_W-1:0] req_out_tid,
  output logic [PKT_W-1:0] req_out_pkt,
  input  logic             rsp_in_valid,
  output logic             rsp_in_ready,
  input  logic [TID_W-1:0] rsp_in_tid,
  output logic             rsp_out_valid,
  input  logic             rsp_out_ready,
  output logic [SRC_W-1:0] rsp_out_src,
  output logic [TID_W-1:0] rsp_out_tid,
  output logic [PKT_W-1:0] rsp_out_pkt,
  output logic             rsp_out_err
);
  localparam int IDX_W = idx_width(DEPTH);

  // Named internal events, observed by the bound checker.
  logic [DEPTH-1:0] busy_mask;
  logic             any_free;
  logic [IDX_W-1:0] alloc_idx;
  logic             alloc_fire;
  logic             release_fire;
  logic [IDX_W-1:0] release_idx;
  logic             rsp_capture;
  logic             lookup_hit;
  logic             pending_hit;
  logic             in_range;
  logic [IDX_W-1:0] rsp_idx;

  logic [SRC_W-1:0] rd_src;
  logic [TID_W-1:0] rd_tid;
  logic [PKT_W-1:0] rd_pkt;

  // Forward stage registers.
  logic             q_valid;
  logic [SRC_W-1:0] q_src;
  logic [TID_W-1:0] q_tid;
  logic [PKT_W-1:0] q_pkt;

  // Return-side holding registers.
  logic             h_valid;
  logic             h_err;
  logic [IDX_W-1:0] h_idx;
  logic [SRC_W-1:0] h_src;
  logic [TID_W-1:0] h_tid;
  logic [PKT_W-1:0] h_pkt;

  xid_pick_free #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_pick (
    .busy     (busy_mask),
    .any_free (any_free),
    .free_idx (alloc_idx)
  );

  xid_tag_table #(
    .DEPTH(DEPTH), .IDX_W(IDX_W), .SRC_W(SRC_W), .TID_W(TID_W), .PKT_W(PKT_W)
  ) u_table (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (alloc_fire),
    .wr_idx  (alloc_idx),
    .wr_src  (req_in_src),
    .wr_tid  (req_in_tid),
    .wr_pkt  (req_in_pkt),
    .clr_en  (release_fire),
    .clr_idx (release_idx),
    .rd_idx  (in_range ? rsp_idx : '0),
    .rd_src  (rd_src),
    .rd_tid  (rd_tid),
    .rd_pkt  (rd_pkt),
    .busy    (busy_mask)
  );

  // Request side: allocate on handshake, forward one cycle later.
  assign req_in_ready = any_free && (!q_valid || req_out_ready);
  assign alloc_fire   = req_in_valid && req_in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_valid <= 1'b0;
      q_src   <= '0;
      q_tid   <= '0;
      q_pkt   <= '0;
    end else if (alloc_fire) begin
      q_valid <= 1'b1;
      q_src   <= OWN_SRC;
      q_tid   <= TID_W'(alloc_idx);
      q_pkt   <= req_in_pkt;
    end else if (req_out_ready) begin
      q_valid <= 1'b0;
    end
  end

  assign req_out_valid = q_valid;
  assign req_out_src   = q_src;
  assign req_out_tid   = q_tid;
  assign req_out_pkt   = q_pkt;

  // Response side: look up the slot, capture into the holding stage.
  assign rsp_idx      = rsp_in_tid[IDX_W-1:0];
  assign in_range     = in_table(64'(rsp_in_tid), DEPTH);
  assign pending_hit  = h_valid && !h_err && (h_idx == rsp_idx);
  assign lookup_hit   = in_range && busy_mask[rsp_idx] && !pending_hit;
  assign rsp_in_ready = !h_valid || rsp_out_ready;
  assign rsp_capture  = rsp_in_valid && rsp_in_ready;
  assign release_fire = h_valid && !h_err && rsp_out_ready;
  assign release_idx  = h_idx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      h_valid <= 1'b0;
      h_err   <= 1'b0;
      h_idx   <= '0;
      h_src   <= '0;
      h_tid   <= '0;
      h_pkt   <= '0;
    end else if (rsp_capture) begin
      h_valid <= 1'b1;
      h_err   <= !lookup_hit;
      h_idx   <= rsp_idx;
      h_src   <= lookup_hit ? rd_src : '0;
      h_tid   <= lookup_hit ? rd_tid : '0;
      h_pkt   <= lookup_hit ? rd_pkt : '0;
    end else if (rsp_out_ready) begin
      h_valid <= 1'b0;
    end
  end

  assign rsp_out_valid = h_valid;
  assign rsp_out_err   = h_err;
  assign rsp_out_src   = h_src;
  assign rsp_out_tid   = h_tid;
  assign rsp_out_pkt   = h_pkt;
endmodule

// File: rtl/xid_remap_checker.sv
module xid_remap_checker
  import xid_remap_pkg::*;
#(
  parameter int               DEPTH   = 4,
  parameter int               SRC_W   = 8,
  parameter int               TID_W   = 4,
  parameter int               PKT_W   = 4,
  parameter int               IDX_W   = 2,
  parameter logic [SRC_W-1:0] OWN_SRC = 8'hA5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_in_ready,
  input logic             req_out_valid,
  input logic             req_out_ready,
  input logic [SRC_W-1:0] req_out_src,
  input logic [TID_W-1:0] req_out_tid,
  input logic [PKT_W-1:0] req_out_pkt,
  input logic             rsp_out_valid,
  input logic             rsp_out_ready,
  input logic [SRC_W-1:0] rsp_out_src,
  input logic [TID_W-1:0] rsp_out_tid,
  input logic [PKT_W-1:0] rsp_out_pkt,
  input logic             rsp_out_err,
  input logic [DEPTH-1:0] busy_mask,
  input logic             alloc_fire,
  input logic [IDX_W-1:0] alloc_idx,
  input logic             release_fire,
  input logic [IDX_W-1:0] release_idx,
  input logic             rsp_capture,
  input logic             lookup_hit
);
  logic [DEPTH-1:0] lower_slots;
  assign lower_slots = DEPTH'(below_mask(int'(alloc_idx)));

  assert_reset_clears_R1: assert property (@(posedge clk)
    !rst_n |=> (!req_out_valid && !rsp_out_valid && busy_mask == '0));

  assert_own_src_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_out_valid |-> req_out_src == OWN_SRC);

  assert_tid_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_out_valid |-> 32'(req_out_tid) < 32'(DEPTH));

  assert_alloc_free_R3: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_fire |-> !busy_mask[alloc_idx]);

  assert_alloc_lowest_R3: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_fire |-> ((~busy_mask) & lower_slots) == '0);

  assert_full_stall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (&busy_mask) |-> !req_in_ready);

  assert_alloc_marks_R6: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_fire |=> busy_mask[$past(alloc_idx)]);

  assert_release_frees_R6: assert property (@(posedge clk) disable iff (!rst_n)
    release_fire |=> !busy_mask[$past(release_idx)]);

  assert_err_no_change_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_capture && !lookup_hit && !alloc_fire && !release_fire) |=> $stable(busy_mask));

  assert_req_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_out_valid && !req_out_ready) |=>
      (req_out_valid && $stable(req_out_tid) && $stable(req_out_pkt)));

  assert_rsp_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_out_valid && !rsp_out_ready) |=>
      (rsp_out_valid && $stable({rsp_out_src, rsp_out_tid, rsp_out_pkt, rsp_out_err})));
endmodule

bind xid_remap_table xid_remap_checker #(
  .DEPTH(DEPTH), .SRC_W(SRC_W), .TID_W(TID_W), .PKT_W(PKT_W),
  .IDX_W(IDX_W), .OWN_SRC(OWN_SRC)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_in_ready  (req_in_ready),
  .req_out_valid (req_out_valid),
  .req_out_ready (req_out_ready),
  .req_out_src   (req_out_src),
  .req_out_tid   (req_out_tid),
  .req_out_pkt   (req_out_pkt),
  .rsp_out_valid (rsp_out_valid),
  .rsp_out_ready (rsp_out_ready),
  .rsp_out_src   (rsp_out_src),
  .rsp_out_tid   (rsp_out_tid),
  .rsp_out_pkt   (rsp_out_pkt),
  .rsp_out_err   (rsp_out_err),
  .busy_mask     (busy_mask),
  .alloc_fire    (alloc_fire),
  .alloc_idx     (alloc_idx),
  .release_fire  (release_fire),
  .release_idx   (release_idx),
  .rsp_capture   (rsp_capture),
  .lookup_hit    (lookup_hit)
);

// File: tb/xid_remap_table_bench.sv
module xid_remap_table_bench;
  localparam int        DEPTH   = 4;
  localparam int        SRC_W   = 8;
  localparam int        TID_W   = 4;
  localparam int        PKT_W   = 4;
  localparam logic [7:0] OWN_SRC = 8'hA5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic             req_in_valid = 1'b0, req_in_ready;
  logic [SRC_W-1:0] req_in_src = '0;
  logic [TID_W-1:0] req_in_tid = '0;
  logic [PKT_W-1:0] req_in_pkt = '0;
  logic             req_out_valid, req_out_ready = 1'b1;
  logic [SRC_W-1:0] req_out_src;
  logic [TID_W-1:0] req_out_tid;
  logic [PKT_W-1:0] req_out_pkt;
  logic             rsp_in_valid = 1'b0, rsp_in_ready;
  logic [TID_W-1:0] rsp_in_tid = '0;
  logic             rsp_out_valid, rsp_out_ready = 1'b1, rsp_out_err;
  logic [SRC_W-1:0] rsp_out_src;
  logic [TID_W-1:0] rsp_out_tid;
  logic [PKT_W-1:0] rsp_out_pkt;

  xid_remap_table #(
    .DEPTH(DEPTH), .SRC_W(SRC_W), .TID_W(TID_W), .PKT_W(PKT_W), .OWN_SRC(OWN_SRC)
  ) u_xid_remap_table (.*);

  int total = 0;
  int bad = 0;
  int cycles = 0;

  // Reference model of the slot table and both output stages.
  logic [DEPTH-1:0] m_busy;
  logic [SRC_W-1:0] m_src [DEPTH];
  logic [TID_W-1:0] m_tid [DEPTH];
  logic [PKT_W-1:0] m_pkt [DEPTH];
  logic             m_qv, m_hv, m_herr;
  logic [TID_W-1:0] m_qtid, m_htid;
  logic [PKT_W-1:0] m_qpkt, m_hpkt;
  logic [SRC_W-1:0] m_hsrc;
  int               m_hidx;

  function automatic int first_free(input logic [DEPTH-1:0] b);
    for (int i = 0; i < DEPTH; i++) if (b[i] == 1'b0) return i;
    return -1;
  endfunction

  function automatic logic exp_in_ready(input logic [DEPTH-1:0] b, input logic qv,
                                        input logic ordy);
    return (first_free(b) >= 0) && (!qv || ordy);
  endfunction

  function automatic logic slot_ok(input int idx);
    if (idx >= DEPTH) return 1'b0;
    if (!m_busy[idx]) return 1'b0;
    if (m_hv && !m_herr && m_hidx == idx) return 1'b0;
    return 1'b1;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = '0; m_qv = 0; m_hv = 0; m_herr = 0; m_hidx = 0;
      m_qtid = '0; m_qpkt = '0; m_hsrc = '0; m_htid = '0; m_hpkt = '0;
    end else begin
      logic acc, rel, cap, ok;
      int lo, ix;
      lo  = first_free(m_busy);
      acc = req_in_valid && exp_in_ready(m_busy, m_qv, req_out_ready);
      rel = m_hv && !m_herr && rsp_out_ready;
      cap = rsp_in_valid && (!m_hv || rsp_out_ready);
      ix  = int'(rsp_in_tid);
      ok  = slot_ok(ix);
      if (cap) begin
        m_herr = !ok;
        m_hsrc = ok ? m_src[ix] : '0;
        m_htid = ok ? m_tid[ix] : '0;
        m_hpkt = ok ? m_pkt[ix] : '0;
      end
      if (rel) m_busy[m_hidx] = 1'b0;
      if (cap) begin m_hv = 1; m_hidx = ix; end
      else if (rsp_out_ready) m_hv = 0;
      if (acc) begin
        m_busy[lo] = 1'b1;
        m_src[lo] = req_in_src; m_tid[lo] = req_in_tid; m_pkt[lo] = req_in_pkt;
        m_qv = 1; m_qtid = TID_W'(lo); m_qpkt = req_in_pkt;
      end else if (req_out_ready) m_qv = 0;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // Full output comparison against the model; called on a falling edge.
  task automatic compare_all();
    chk("R4 req_in_ready", 32'(req_in_ready), 32'(exp_in_ready(m_busy, m_qv, req_out_ready)));
    chk("R8 rsp_in_ready", 32'(rsp_in_ready), 32'(!m_hv || rsp_out_ready));
    chk("R2 req_out_valid", 32'(req_out_valid), 32'(m_qv));
    if (m_qv) begin
      chk("R2 req_out_src", 32'(req_out_src), 32'(OWN_SRC));
      chk("R3 req_out_tid", 32'(req_out_tid), 32'(m_qtid));
      chk("R2 req_out_pkt", 32'(req_out_pkt), 32'(m_qpkt));
    end
    chk("R5 rsp_out_valid", 32'(rsp_out_valid), 32'(m_hv));
    if (m_hv) begin
      chk("R7 rsp_out_err", 32'(rsp_out_err), 32'(m_herr));
      chk("R5 rsp_out_src", 32'(rsp_out_src), 32'(m_hsrc));
      chk("R5 rsp_out_tid", 32'(rsp_out_tid), 32'(m_htid));
      chk("R5 rsp_out_pkt", 32'(rsp_out_pkt), 32'(m_hpkt));
    end
  endtask

  task automatic tick();
    @(negedge clk);
    compare_all();
  endtask

  function automatic logic [TID_W-1:0] pick_rsp_tid(input int p_bad);
    int start;
    if (int'($urandom_range(99)) < p_bad) return TID_W'($urandom);
    start = int'($urandom_range(DEPTH - 1));
    for (int k = 0; k < DEPTH; k++) begin
      int s;
      s = (start + k) % DEPTH;
      if (m_busy[s]) return TID_W'(s);
    end
    return TID_W'($urandom);
  endfunction

  task automatic random_phase(input int n, input int p_req, input int p_qr,
                              input int p_rsp, input int p_sr, input int p_bad);
    for (int c = 0; c < n; c++) begin
      req_in_valid  = int'($urandom_range(99)) < p_req;
      req_in_src    = SRC_W'($urandom);
      req_in_tid    = TID_W'($urandom);
      req_in_pkt    = PKT_W'($urandom);
      req_out_ready = int'($urandom_range(99)) < p_qr;
      rsp_in_valid  = int'($urandom_range(99)) < p_rsp;
      rsp_in_tid    = pick_rsp_tid(p_bad);
      rsp_out_ready = int'($urandom_range(99)) < p_sr;
      tick();
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      bad++; total++;
      $display("FAIL watchdog act=%0d exp=<150000", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    @(negedge clk);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tick();
    // R1: reset state
    chk("R1 req_out_valid", 32'(req_out_valid), 0);
    chk("R1 rsp_out_valid", 32'(rsp_out_valid), 0);
    chk("R1 req_in_ready", 32'(req_in_ready), 1);

    // Fill every slot; R3 expects indices 0,1,2,3 in turn.
    for (int i = 0; i < DEPTH; i++) begin
      req_in_valid = 1; req_in_src = SRC_W'(8'h10 + i);
      req_in_tid = TID_W'(i ^ 3); req_in_pkt = PKT_W'(i + 5);
      tick();
      chk("R3 fill order", 32'(req_out_tid), 32'(i));
      chk("R2 fill src", 32'(req_out_src), 32'(OWN_SRC));
    end
    tick();
    chk("R4 full stall", 32'(req_in_ready), 0);

    // Response for slot 2 with the return channel stalled.
    req_in_valid = 0; rsp_in_valid = 1; rsp_in_tid = 4'd2; rsp_out_ready = 0;
    tick();
    chk("R5 restored src", 32'(rsp_out_src), 32'h12);
    chk("R5 restored tid", 32'(rsp_out_tid), 32'(2 ^ 3));
    chk("R5 restored pkt", 32'(rsp_out_pkt), 32'(7));
    chk("R5 err clear", 32'(rsp_out_err), 0);
    rsp_in_valid = 0; req_in_valid = 1; req_in_src = 8'h55; req_in_pkt = 4'h9;
    tick();
    chk("R9 held src", 32'(rsp_out_src), 32'h12);
    chk("R4 still full", 32'(req_in_ready), 0);
    rsp_out_ready = 1;
    tick();
    chk("R6 freed next cycle", 32'(req_in_ready), 1);
    tick();
    chk("R6 reuse slot", 32'(req_out_tid), 32'(2));
    req_in_valid = 0;

    // Out-of-range index: error response, no slot change.
    rsp_in_valid = 1; rsp_in_tid = 4'd9;
    tick();
    chk("R7 err set", 32'(rsp_out_err), 1);
    chk("R7 err src zero", 32'(rsp_out_src), 0);
    rsp_in_valid = 0;
    tick();
    chk("R7 table unchanged", 32'(req_in_ready), 0);

    random_phase(1500, 60, 70, 50, 70, 10);
    random_phase(1500, 90, 30, 20, 40, 5);
    random_phase(1500, 40, 90, 80, 90, 30);
    random_phase(1000, 95, 95, 95, 95, 0);

    req_in_valid = 0; rsp_in_valid = 0;
    tick();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule